// File: doc/BRIEF.md
# Multi-Bank Flash Command Sequencer

This block sits between a host bus and the cell array of a multi-bank NOR-style flash. It watches host write cycles (a bank-plus-offset address and a 16-bit data word) and keeps a separate mode for every bank. The modes are plain array reads, a query-table mode, an identification mode, a fast-program bypass mode, a running sector erase, a suspended erase and a latched fault. The host reads at any time through a combinational read port. The block chooses what the addressed bank returns: array data from the outside array, a query-table word, an identification word or sector protection bit, or a status word.

Commands are matched on the low byte of the data word only. Most of them follow a two-write unlock prefix: AAh at offset 555h, then 55h at offset 2AAh. Erase runs for a fixed number of cycles. It can be paused and resumed, and an external fault input stops it. Program work goes out as a one-cycle request that carries a word count. The request comes either from the bypass mode or from a buffered-write sequence whose length is set by a count word and capped in total bus cycles. A write that does not fit the bank's current mode or sequence step leaves that bank's mode as it is and raises that bank's sticky error flag.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset every bank is in array mode, `cmd_err` and `erase_busy` are all zero, no program request is issued, and reads of any bank return `arr_rdata` unchanged with no command writes needed.
- R2: A write whose low byte is 98h at in-bank offset 555h, to a bank in array or suspended-erase mode, puts that bank in query mode. Data bits 15..8 of every command write are ignored. In query mode, offsets 10h, 11h and 12h read 0051h, 0052h and 0059h, offsets 13h..1Fh read 00h followed by the offset byte, and any other offset reads FFFFh.
- R3: Low byte F0h ends query or identification mode and clears the bank's error flag. The bank returns to array mode, or to suspended-erase mode if it entered from there. In array or suspended mode, F0h abandons a partial command sequence.
- R4: While any bank is in query mode, writes to every other bank are ignored: no mode change, no sequence progress, no error. Reads of those banks still return array data.
- R5: AAh@555h, 55h@2AAh, 90h@555h enter identification mode. In this mode offset low byte 00h reads MFR_ID, 01h reads DEV_ID, and 02h reads 0001h if the sector is protected and 0000h if not. The sector is the top SECT_W offset bits, and its protection bit is `lock_bits[bank*2^SECT_W + sector]`. All other offsets read 0000h.
- R6: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, then 30h at any offset start a sector erase. `erase_busy[bank]` stays high for exactly ERASE_CYC cycles, and reads of that bank return 0000h while it is high.
- R7: B0h to an erasing bank suspends the erase: `erase_busy` drops, reads return array data and the erase timer holds. A later 30h resumes the erase for its remaining cycles. B0h to a bank that is not erasing is rejected.
- R8: AAh@555h, 55h@2AAh, 20h@555h enter bypass. There, A0h followed by any word issues a program request of one word. F0h is rejected and bypass is kept. Only 90h followed by 00h leaves bypass.
- R9: AAh@555h, 55h@2AAh, 25h, count c, then c+1 data words and 29h issue a program request of c+1 words. A count with c+6 > WB_MAX_CYC total cycles aborts at the count write with an error. A confirm other than 29h aborts with an error. Neither abort issues a request.
- R10: A fault input pulse during an erase puts the bank in fault mode. `erase_busy` drops, reads return 0020h (bit 5 set), and every write except F0h is rejected until F0h returns the bank to array mode.
- R11: An unrecognised or out-of-sequence write leaves the bank's mode unchanged and sets that bank's `cmd_err` bit, which stays set until F0h is accepted by that bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one write per asserted cycle |
| wr_addr | input | log2(NBANKS)+OFS_W | Write address: bank in the top bits, word offset below |
| wr_data | input | 16 | Write data; only bits 7..0 are decoded |
| rd_addr | input | log2(NBANKS)+OFS_W | Read address, same layout as wr_addr |
| arr_rdata | input | 16 | Array word at rd_addr, from the cell array |
| lock_bits | input | NBANKS*2^SECT_W | Sector protection bits, one per sector |
| op_fault | input | NBANKS | Per-bank operation fault pulse |
| rd_data | output | 16 | Combinational read data for rd_addr |
| cmd_err | output | NBANKS | Sticky per-bank command error flags |
| erase_busy | output | NBANKS | Bank is running a sector erase |
| prog_commit | output | 1 | One-cycle program request |
| prog_words | output | clog2(WB_MAX_CYC+1) | Word count of the program request |

## Verification
The hardest state to reach is a bank that sits in identification mode on top of a suspended erase while the erase timer is frozen part of the way through. Getting there takes the full six-write erase, a wait, a suspend, a second unlock prefix and the identify command. The state is then left with a reset, which must land back in the suspended state and not in array mode. The bench drives this path directly. After resuming, it measures that the remaining busy time is shorter than a full erase. The blocked-write rule for query mode is also hard to see from the ports, because an ignored write has no visible result. The bench shows that the sequencer did not advance by writing the second unlock word after the query bank exits and seeing it rejected. Buffered-write counts are drawn at random around the cycle cap, with the exact limits forced as directed cases.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  typedef enum logic [2:0] {
    M_ARRAY,
    M_CFI,
    M_AUTOSEL,
    M_BYPASS,
    M_ERASE,
    M_ESUSP,
    M_FAULT
  } fcs_mode_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_U1,
    S_U2,
    S_ES1,
    S_ES2,
    S_ES3,
    S_WB_CNT,
    S_WB_DATA,
    S_WB_CONF,
    S_BP_PROG,
    S_BP_RST
  } fcs_step_e;

  localparam logic [7:0] C_RESET   = 8'hF0;
  localparam logic [7:0] C_UNL1    = 8'hAA;
  localparam logic [7:0] C_UNL2    = 8'h55;
  localparam logic [7:0] C_QUERY   = 8'h98;
  localparam logic [7:0] C_IDENT   = 8'h90;
  localparam logic [7:0] C_ESETUP  = 8'h80;
  localparam logic [7:0] C_ERASE   = 8'h30;
  localparam logic [7:0] C_BYPASS  = 8'h20;
  localparam logic [7:0] C_WBUF    = 8'h25;
  localparam logic [7:0] C_WBCONF  = 8'h29;
  localparam logic [7:0] C_SUSPEND = 8'hB0;
  localparam logic [7:0] C_BPPROG  = 8'hA0;
  localparam logic [7:0] C_BPEXIT  = 8'h00;

  localparam logic [11:0] OFS_KEY_A = 12'h555;
  localparam logic [11:0] OFS_KEY_B = 12'h2AA;

  localparam logic [15:0] CFI_FILL    = 16'hFFFF;
  localparam logic [15:0] STAT_BUSY   = 16'h0000;
  localparam logic [15:0] STAT_FAULT  = 16'h0020;

  // total bus cycles of a buffered write carrying n data words:
  // two unlock writes, command, count, n words, confirm
  function automatic logic [9:0] wbuf_total(input logic [8:0] nwords);
    return {1'b0, nwords} + 10'd5;
  endfunction

  // small stand-in for the query table contents
  function automatic logic [15:0] cfi_rom(input logic [7:0] idx);
    case (idx)
      8'h10:   return 16'h0051;
      8'h11:   return 16'h0052;
      8'h12:   return 16'h0059;
      default: return {8'h00, idx};
    endcase
  endfunction

endpackage

// File: rtl/fcs_bank_ctrl.sv
module fcs_bank_ctrl
  import fcs_pkg::*;
#(
  parameter int OFS_W      = 12,
  parameter int ERASE_CYC  = 64,
  parameter int WB_MAX_CYC = 37,
  parameter int CW         = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_hit,
  input  logic [OFS_W-1:0] wr_ofs,
  input  logic [7:0]      wr_byte,
  input  logic            fault_in,
  output fcs_mode_e       mode_o,
  output logic            err_o,
  output logic            reject_o,
  output logic            prog_o,
  output logic [CW-1:0]   prog_len_o
);

  localparam int TW = $clog2(ERASE_CYC + 1);
  localparam logic [TW-1:0] TLAST = TW'(ERASE_CYC - 1);
  localparam logic [9:0] WB_CAP = 10'(WB_MAX_CYC);

  fcs_mode_e mode_q, mode_d;
  fcs_step_e step_q, step_d;
  logic          susp_q, susp_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] len_q, len_d;
  logic          prog_q, prog_d;
  logic [CW-1:0] plen_q, plen_d;
  logic          err_q;
  logic          rej, clr;

  logic       at_a, at_b, erase_done;
  logic [8:0] nwords;

  assign at_a       = (wr_ofs[11:0] == OFS_KEY_A);
  assign at_b       = (wr_ofs[11:0] == OFS_KEY_B);
  assign erase_done = (mode_q == M_ERASE) && (tmr_q == TLAST);
  assign nwords     = {1'b0, wr_byte} + 9'd1;

  always_comb begin
    mode_d = mode_q;
    step_d = step_q;
    susp_d = susp_q;
    tmr_d  = tmr_q;
    cnt_d  = cnt_q;
    len_d  = len_q;
    prog_d = 1'b0;
    plen_d = plen_q;
    rej    = 1'b0;
    clr    = 1'b0;

    if (mode_q == M_ERASE) tmr_d = tmr_q + TW'(1);

    if (mode_q == M_ERASE && fault_in) begin
      mode_d = M_FAULT;
      step_d = S_IDLE;
    end else if (erase_done) begin
      mode_d = M_ARRAY;
      step_d = S_IDLE;
    end else if (wr_hit) begin
      if (wr_byte == C_RESET && step_q != S_WB_DATA &&
          mode_q != M_BYPASS && mode_q != M_ERASE) begin
        clr    = 1'b1;
        step_d = S_IDLE;
        case (mode_q)
          M_CFI, M_AUTOSEL: begin
            mode_d = susp_q ? M_ESUSP : M_ARRAY;
            susp_d = 1'b0;
          end
          M_FAULT: mode_d = M_ARRAY;
          default: ;
        endcase
      end else begin
        case (mode_q)
          M_ARRAY, M_ESUSP: begin
            case (step_q)
              S_IDLE: begin
                if (wr_byte == C_QUERY && at_a) begin
                  mode_d = M_CFI;
                  susp_d = (mode_q == M_ESUSP);
                end else if (wr_byte == C_UNL1 && at_a) begin
                  step_d = S_U1;
                end else if (mode_q == M_ESUSP && wr_byte == C_ERASE) begin
                  mode_d = M_ERASE;
                end else begin
                  rej = 1'b1;
                end
              end
              S_U1: begin
                if (wr_byte == C_UNL2 && at_b) step_d = S_U2;
                else begin
                  rej    = 1'b1;
                  step_d = S_IDLE;
                end
              end
              S_U2: begin
                step_d = S_IDLE;
                if (wr_byte == C_IDENT && at_a) begin
                  mode_d = M_AUTOSEL;
                  susp_d = (mode_q == M_ESUSP);
                end else if (mode_q == M_ARRAY && wr_byte == C_ESETUP && at_a) begin
                  step_d = S_ES1;
                end else if (mode_q == M_ARRAY && wr_byte == C_BYPASS && at_a) begin
                  mode_d = M_BYPASS;
                end else if (wr_byte == C_WBUF) begin
                  step_d = S_WB_CNT;
                end else begin
                  rej = 1'b1;
                end
              end
              S_ES1: begin
                if (wr_byte == C_UNL1 && at_a) step_d = S_ES2;
                else begin
                  rej    = 1'b1;
                  step_d = S_IDLE;
                end
              end
              S_ES2: begin
                if (wr_byte == C_UNL2 && at_b) step_d = S_ES3;
                else begin
                  rej    = 1'b1;
                  step_d = S_IDLE;
                end
              end
              S_ES3: begin
                step_d = S_IDLE;
                if (wr_byte == C_ERASE) begin
                  mode_d = M_ERASE;
                  tmr_d  = '0;
                end else begin
                  rej = 1'b1;
                end
              end
              S_WB_CNT: begin
                if (wbuf_total(nwords) > WB_CAP) begin
                  rej    = 1'b1;
                  step_d = S_IDLE;
                end else begin
                  cnt_d  = nwords[CW-1:0];
                  len_d  = nwords[CW-1:0];
                  step_d = S_WB_DATA;
                end
              end
              S_WB_DATA: begin
                cnt_d = cnt_q - CW'(1);
                if (cnt_q == CW'(1)) step_d = S_WB_CONF;
              end
              S_WB_CONF: begin
                step_d = S_IDLE;
                if (wr_byte == C_WBCONF) begin
                  prog_d = 1'b1;
                  plen_d = len_q;
                end else begin
                  rej = 1'b1;
                end
              end
              default: begin
                rej    = 1'b1;
                step_d = S_IDLE;
              end
            endcase
          end
          M_ERASE: begin
            if (wr_byte == C_SUSPEND) mode_d = M_ESUSP;
            else rej = 1'b1;
          end
          M_BYPASS: begin
            case (step_q)
              S_BP_PROG: begin
                prog_d = 1'b1;
                plen_d = CW'(1);
                step_d = S_IDLE;
              end
              S_BP_RST: begin
                step_d = S_IDLE;
                if (wr_byte == C_BPEXIT) mode_d = M_ARRAY;
                else rej = 1'b1;
              end
              default: begin
                if (wr_byte == C_BPPROG) step_d = S_BP_PROG;
                else if (wr_byte == C_IDENT) step_d = S_BP_RST;
                else rej = 1'b1;
              end
            endcase
          end
          default: rej = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_ARRAY;
      step_q <= S_IDLE;
      susp_q <= 1'b0;
      tmr_q  <= '0;
      cnt_q  <= '0;
      len_q  <= '0;
      prog_q <= 1'b0;
      plen_q <= '0;
      err_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      step_q <= step_d;
      susp_q <= susp_d;
      tmr_q  <= tmr_d;
      cnt_q  <= cnt_d;
      len_q  <= len_d;
      prog_q <= prog_d;
      plen_q <= plen_d;
      if (clr)      err_q <= 1'b0;
      else if (rej) err_q <= 1'b1;
    end
  end

  assign mode_o     = mode_q;
  assign err_o      = err_q;
  assign reject_o   = rej;
  assign prog_o     = prog_q;
  assign prog_len_o = plen_q;

endmodule

// File: rtl/fcs_read_mux.sv
module fcs_read_mux
  import fcs_pkg::*;
#(
  parameter int          NBANKS  = 4,
  parameter int          OFS_W   = 12,
  parameter int          SECT_W  = 2,
  parameter int          CFI_LEN = 16,
  parameter logic [15:0] DEV_ID  = 16'h223C,
  parameter logic [15:0] MFR_ID  = 16'h0001,
  parameter int          BW      = 2
) (
  input  fcs_mode_e [NBANKS-1:0]        modes,
  input  logic [BW-1:0]                 rd_bank,
  input  logic [OFS_W-1:0]              rd_ofs,
  input  logic [15:0]                   arr_rdata,
  input  logic [NBANKS*(1<<SECT_W)-1:0] lock_bits,
  output logic [15:0]                   rd_data
);

  localparam int LW = BW + SECT_W;
  localparam logic [OFS_W-1:0] CFI_LO = OFS_W'(16);
  localparam logic [OFS_W-1:0] CFI_HI = OFS_W'(16 + CFI_LEN);

  fcs_mode_e         mode_r;
  logic [SECT_W-1:0] sector;
  logic [LW-1:0]     lock_idx;
  logic              in_win;
  logic [15:0]       auto_word;

  assign mode_r   = modes[rd_bank];
  assign sector   = rd_ofs[OFS_W-1 -: SECT_W];
  assign lock_idx = {rd_bank, sector};
  assign in_win   = (rd_ofs >= CFI_LO) && (rd_ofs < CFI_HI);

  always_comb begin
    case (rd_ofs[7:0])
      8'h00:   auto_word = MFR_ID;
      8'h01:   auto_word = DEV_ID;
      8'h02:   auto_word = {15'd0, lock_bits[lock_idx]};
      default: auto_word = 16'h0000;
    endcase
  end

  always_comb begin
    case (mode_r)
      M_CFI:     rd_data = in_win ? cfi_rom(rd_ofs[7:0]) : CFI_FILL;
      M_AUTOSEL: rd_data = auto_word;
      M_ERASE:   rd_data = STAT_BUSY;
      M_FAULT:   rd_data = STAT_FAULT;
      default:   rd_data = arr_rdata;
    endcase
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int          NBANKS     = 4,
  parameter int          OFS_W      = 12,
  parameter int          SECT_W     = 2,
  parameter int          ERASE_CYC  = 64,
  parameter int          WB_MAX_CYC = 37,
  parameter int          CFI_LEN    = 16,
  parameter logic [15:0] DEV_ID     = 16'h223C,
  parameter logic [15:0] MFR_ID     = 16'h0001,
  localparam int         BW         = $clog2(NBANKS),
  localparam int         AW         = BW + OFS_W,
  localparam int         NSECT      = 1 << SECT_W,
  localparam int         CW         = $clog2(WB_MAX_CYC + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [15:0]             wr_data,
  input  logic [AW-1:0]           rd_addr,
  input  logic [15:0]             arr_rdata,
  input  logic [NBANKS*NSECT-1:0] lock_bits,
  input  logic [NBANKS-1:0]       op_fault,
  output logic [15:0]             rd_data,
  output logic [NBANKS-1:0]       cmd_err,
  output logic [NBANKS-1:0]       erase_busy,
  output logic                    prog_commit,
  output logic [CW-1:0]           prog_words
);

  logic [BW-1:0]    wr_bank;
  logic [OFS_W-1:0] wr_ofs;
  logic [7:0]       cmd_byte;
  logic             unused_hi;

  fcs_mode_e [NBANKS-1:0] modes;
  logic [NBANKS-1:0] cfi_vec;
  logic [NBANKS-1:0] bank_hit;
  logic [NBANKS-1:0] reject_vec;
  logic [NBANKS-1:0] prog_vec;
  logic [CW-1:0]     plen [NBANKS];
  logic              wr_block;

  assign wr_bank   = wr_addr[AW-1:OFS_W];
  assign wr_ofs    = wr_addr[OFS_W-1:0];
  assign cmd_byte  = wr_data[7:0];
  assign unused_hi = ^wr_data[15:8];

  // a bank in query mode locks out writes aimed at any other bank
  assign wr_block = wr_en && (|cfi_vec) && !cfi_vec[wr_bank];

  for (genvar g = 0; g < NBANKS; g++) begin : g_bank
    assign bank_hit[g]   = wr_en && !wr_block && (wr_bank == BW'(g));
    assign cfi_vec[g]    = (modes[g] == M_CFI);
    assign erase_busy[g] = (modes[g] == M_ERASE);

    fcs_bank_ctrl #(
      .OFS_W     (OFS_W),
      .ERASE_CYC (ERASE_CYC),
      .WB_MAX_CYC(WB_MAX_CYC),
      .CW        (CW)
    ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_hit    (bank_hit[g]),
      .wr_ofs    (wr_ofs),
      .wr_byte   (cmd_byte),
      .fault_in  (op_fault[g]),
      .mode_o    (modes[g]),
      .err_o     (cmd_err[g]),
      .reject_o  (reject_vec[g]),
      .prog_o    (prog_vec[g]),
      .prog_len_o(plen[g])
    );
  end

  always_comb begin
    prog_commit = 1'b0;
    prog_words  = '0;
    for (int i = 0; i < NBANKS; i++) begin
      if (prog_vec[i]) begin
        prog_commit = 1'b1;
        prog_words  = prog_words | plen[i];
      end
    end
  end

  fcs_read_mux #(
    .NBANKS (NBANKS),
    .OFS_W  (OFS_W),
    .SECT_W (SECT_W),
    .CFI_LEN(CFI_LEN),
    .DEV_ID (DEV_ID),
    .MFR_ID (MFR_ID),
    .BW     (BW)
  ) u_rdmux (
    .modes    (modes),
    .rd_bank  (rd_addr[AW-1:OFS_W]),
    .rd_ofs   (rd_addr[OFS_W-1:0]),
    .arr_rdata(arr_rdata),
    .lock_bits(lock_bits),
    .rd_data  (rd_data)
  );

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int NBANKS     = 4,
  parameter int CW         = 6,
  parameter int WB_MAX_CYC = 37
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wr_block,
  input logic [NBANKS-1:0] cfi_vec,
  input logic [NBANKS-1:0] reject_vec,
  input logic [NBANKS-1:0] cmd_err,
  input logic [NBANKS-1:0] erase_busy,
  input logic [NBANKS-1:0] op_fault,
  input logic              prog_commit,
  input logic [CW-1:0]     prog_words
);

  localparam logic [CW-1:0] MAXW = CW'(WB_MAX_CYC - 5);

  assert_single_cfi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cfi_vec) <= 1);

  assert_blocked_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_block |=> $stable(cmd_err));

  assert_err_from_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|(cmd_err & ~$past(cmd_err))) |-> $past(wr_en));

  assert_reject_latches_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|reject_vec) |=> ((cmd_err & $past(reject_vec)) == $past(reject_vec)));

  assert_commit_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    prog_commit |-> (prog_words != '0 && prog_words <= MAXW));

  assert_commit_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    prog_commit |-> $past(wr_en));

  assert_busy_from_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(erase_busy & ~$past(erase_busy))) |-> $past(wr_en));

  assert_fault_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(op_fault & erase_busy)) |=> ((erase_busy & $past(op_fault & erase_busy)) == '0));

endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(
  .NBANKS    (NBANKS),
  .CW        (CW),
  .WB_MAX_CYC(WB_MAX_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_block   (wr_block),
  .cfi_vec    (cfi_vec),
  .reject_vec (reject_vec),
  .cmd_err    (cmd_err),
  .erase_busy (erase_busy),
  .op_fault   (op_fault),
  .prog_commit(prog_commit),
  .prog_words (prog_words)
);

// File: tb/tb_flash_cmd_seq.sv
module tb_flash_cmd_seq;

  localparam int NB = 4;
  localparam int ECYC = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [13:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [13:0] rd_addr = '0;
  logic [15:0] arr_rdata;
  logic [15:0] lock_bits = '0;
  logic [3:0]  op_fault = '0;
  logic [15:0] rd_data;
  logic [3:0]  cmd_err, erase_busy;
  logic        prog_commit;
  logic [5:0]  prog_words;

  int n_chk = 0;
  int n_fail = 0;
  logic       cm_seen;
  logic [5:0] cm_words;

  always #5 clk = ~clk;

  function automatic logic [15:0] arr_model(input logic [13:0] a);
    return {2'b01, a} ^ 16'h3C3C;
  endfunction

  function automatic logic [15:0] exp_query(input logic [11:0] ofs);
    if (ofs < 12'h10 || ofs > 12'h1F) return 16'hFFFF;
    if (ofs == 12'h10) return 16'h0051;
    if (ofs == 12'h11) return 16'h0052;
    if (ofs == 12'h12) return 16'h0059;
    return {8'h00, ofs[7:0]};
  endfunction

  assign arr_rdata = arr_model(rd_addr);

  flash_cmd_seq dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .arr_rdata(arr_rdata),
    .lock_bits(lock_bits), .op_fault(op_fault), .rd_data(rd_data),
    .cmd_err(cmd_err), .erase_busy(erase_busy),
    .prog_commit(prog_commit), .prog_words(prog_words)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // write with random upper byte; leaves time at the next falling edge
  task automatic wr(input int b, input logic [11:0] ofs, input logic [7:0] cmd);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = {b[1:0], ofs};
    wr_data = {8'($urandom()), cmd};
    @(negedge clk);
    wr_en    = 1'b0;
    cm_seen  = prog_commit;
    cm_words = prog_words;
  endtask

  task automatic unl(input int b);
    wr(b, 12'h555, 8'hAA);
    wr(b, 12'h2AA, 8'h55);
  endtask

  task automatic rd(input string req, input int b, input logic [11:0] ofs,
                    input logic [15:0] exp);
    rd_addr = {b[1:0], ofs};
    #1;
    check(req, "rd_data", {16'h0, rd_data}, {16'h0, exp});
  endtask

  task automatic rd_arr(input string req, input int b, input logic [11:0] ofs);
    rd(req, b, ofs, arr_model({b[1:0], ofs}));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n;
    int c;
    int b;
    logic [11:0] o;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1", "cmd_err", 32'(cmd_err), 0);
    check("R1", "erase_busy", 32'(erase_busy), 0);
    check("R1", "prog_commit", 32'(prog_commit), 0);
    for (int k = 0; k < 12; k++) rd_arr("R1", $urandom_range(0, 3), 12'($urandom()));

    // R2 query mode on bank 1, upper data byte random
    wr(1, 12'h555, 8'h98);
    rd("R2", 1, 12'h010, 16'h0051);
    rd("R2", 1, 12'h011, 16'h0052);
    rd("R2", 1, 12'h012, 16'h0059);
    rd("R2", 1, 12'h01F, 16'h001F);
    rd("R2", 1, 12'h020, 16'hFFFF);
    rd("R2", 1, 12'h000, 16'hFFFF);
    for (int k = 0; k < 10; k++) begin
      o = 12'($urandom_range(0, 40));
      rd("R2", 1, o, exp_query(o));
    end
    // R4 other banks readable, writes ignored
    rd_arr("R4", 2, 12'h123);
    wr(2, 12'h555, 8'hAA);
    check("R4", "cmd_err after blocked write", 32'(cmd_err), 0);
    wr(0, 12'h555, 8'h98);
    rd_arr("R4", 0, 12'h010);
    // R11 bad write to query bank
    wr(1, 12'h100, 8'h77);
    check("R11", "cmd_err[1]", 32'(cmd_err[1]), 1);
    rd("R11", 1, 12'h010, 16'h0051);
    // R3 exit
    wr(1, 12'h000, 8'hF0);
    check("R3", "cmd_err[1] cleared", 32'(cmd_err[1]), 0);
    rd_arr("R3", 1, 12'h010);
    // R4 blocked AA did not advance bank 2: the 55h now is out of sequence
    wr(2, 12'h2AA, 8'h55);
    check("R4", "bank2 sequence not advanced", 32'(cmd_err[2]), 1);
    wr(2, 12'h000, 8'hF0);
    check("R3", "cmd_err[2] cleared", 32'(cmd_err[2]), 0);

    // R5 identification
    lock_bits = 16'($urandom());
    unl(3);
    wr(3, 12'h555, 8'h90);
    rd("R5", 3, 12'h000, 16'h0001);
    rd("R5", 3, 12'h001, 16'h223C);
    rd("R5", 3, 12'h007, 16'h0000);
    for (int s = 0; s < 4; s++)
      rd("R5", 3, {2'(s), 10'h002}, {15'd0, lock_bits[12 + s]});
    rd_arr("R5", 0, 12'h002);
    wr(3, 12'h000, 8'hF0);
    rd_arr("R3", 3, 12'h001);

    // R11 out of sequence
    unl(0);
    wr(0, 12'h555, 8'h77);
    check("R11", "cmd_err[0] bad third cycle", 32'(cmd_err[0]), 1);
    rd_arr("R11", 0, 12'h555);
    wr(0, 12'h000, 8'hF0);
    wr(0, 12'h2AA, 8'h55);
    check("R11", "cmd_err[0] lone 55h", 32'(cmd_err[0]), 1);
    wr(0, 12'h000, 8'hF0);
    check("R11", "cmd_err[0] cleared", 32'(cmd_err[0]), 0);

    // R6 full erase duration on bank 1
    unl(1); wr(1, 12'h555, 8'h80); unl(1); wr(1, 12'h800, 8'h30);
    rd("R6", 1, 12'h800, 16'h0000);
    rd_arr("R6", 0, 12'h800);
    n = 0;
    while (erase_busy[1] && n < 1000) begin
      n++;
      @(negedge clk);
    end
    check("R6", "busy cycles", 32'(n), 32'(ECYC));
    rd_arr("R6", 1, 12'h800);

    // R7 suspend, identify on top, resume
    wr(0, 12'h000, 8'hB0);
    check("R7", "suspend on idle bank rejected", 32'(cmd_err[0]), 1);
    wr(0, 12'h000, 8'hF0);
    unl(2); wr(2, 12'h555, 8'h80); unl(2); wr(2, 12'h400, 8'h30);
    check("R6", "erase_busy[2]", 32'(erase_busy[2]), 1);
    repeat (10) @(negedge clk);
    wr(2, 12'h000, 8'hB0);
    check("R7", "busy after suspend", 32'(erase_busy[2]), 0);
    rd_arr("R7", 2, 12'h400);
    repeat (100) @(negedge clk);
    check("R7", "timer held", 32'(erase_busy[2]), 0);
    unl(2); wr(2, 12'h555, 8'h90);
    rd("R7", 2, 12'h001, 16'h223C);
    wr(2, 12'h000, 8'hF0);
    check("R3", "back to suspended", 32'(erase_busy[2]), 0);
    rd_arr("R3", 2, 12'h004);
    wr(2, 12'h000, 8'h30);
    check("R7", "busy after resume", 32'(erase_busy[2]), 1);
    n = 0;
    while (erase_busy[2] && n < 1000) begin
      n++;
      @(negedge clk);
    end
    check("R7", "remaining shorter than full", 32'(n > 0 && n < ECYC), 1);
    check("R7", "no error on bank 2", 32'(cmd_err[2]), 0);

    // R10 fault during erase
    unl(3); wr(3, 12'h555, 8'h80); unl(3); wr(3, 12'h000, 8'h30);
    op_fault = 4'b1000;
    @(negedge clk);
    op_fault = 4'b0000;
    check("R10", "busy after fault", 32'(erase_busy[3]), 0);
    rd("R10", 3, 12'h000, 16'h0020);
    wr(3, 12'h000, 8'h30);
    check("R10", "write rejected in fault", 32'(cmd_err[3]), 1);
    rd("R10", 3, 12'h000, 16'h0020);
    wr(3, 12'h000, 8'hF0);
    rd_arr("R10", 3, 12'h000);
    check("R10", "error cleared", 32'(cmd_err[3]), 0);

    // R8 bypass
    unl(0); wr(0, 12'h555, 8'h20);
    wr(0, 12'h000, 8'hA0);
    wr(0, 12'h123, 8'h5A);
    check("R8", "bypass commit", {31'd0, cm_seen}, 1);
    check("R8", "bypass words", 32'(cm_words), 1);
    wr(0, 12'h000, 8'hF0);
    check("R8", "reset rejected in bypass", 32'(cmd_err[0]), 1);
    wr(0, 12'h000, 8'hA0);
    wr(0, 12'h124, 8'hF0);
    check("R8", "still in bypass", {31'd0, cm_seen}, 1);
    wr(0, 12'h000, 8'h90);
    wr(0, 12'h000, 8'h00);
    wr(0, 12'h000, 8'hA0);
    check("R8", "bypass left", {31'd0, cm_seen}, 0);
    wr(0, 12'h000, 8'hF0);
    check("R8", "error cleared after exit", 32'(cmd_err[0]), 0);

    // R9 buffered writes around the cycle cap
    for (int k = 0; k < 14; k++) begin
      b = $urandom_range(0, 3);
      c = (k == 0) ? 31 : (k == 1) ? 32 : (k == 2) ? 0 : $urandom_range(0, 40);
      unl(b);
      wr(b, 12'h040, 8'h25);
      wr(b, 12'h040, 8'(c));
      if (c + 6 > 37) begin
        check("R9", "abort flags error", 32'(cmd_err[b]), 1);
        check("R9", "abort no commit", {31'd0, cm_seen}, 0);
        wr(b, 12'h000, 8'hF0);
      end else begin
        for (int w = 0; w <= c; w++) wr(b, 12'(64 + w), 8'($urandom()));
        wr(b, 12'h040, 8'h29);
        check("R9", "commit", {31'd0, cm_seen}, 1);
        check("R9", "words", 32'(cm_words), 32'(c + 1));
        check("R9", "no error", 32'(cmd_err[b]), 0);
      end
    end
    unl(1); wr(1, 12'h0, 8'h25); wr(1, 12'h0, 8'd3);
    for (int w = 0; w < 4; w++) wr(1, 12'(w), 8'h11);
    wr(1, 12'h0, 8'h28);
    check("R9", "bad confirm no commit", {31'd0, cm_seen}, 0);
    check("R9", "bad confirm error", 32'(cmd_err[1]), 1);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule